// File: doc/BRIEF.md
# Averaging Conversion Sequencer

This block drives the measurement side of a two-channel shunt and bus monitor. It asks an external converter for one sample at a time, first the shunt channel and then the bus channel. Each request lasts a programmable time, and the two channels take their time codes separately. Each shunt sample gives a current value through a calibration scale factor. Each bus sample gives a power value from that bus sample and the most recent current. All four quantities are summed in accumulators over a programmed number of samples. The averages go to the result registers only when a full set is complete.

A single configuration write sets the mode, the two time codes and the averaging code. A write always abandons any partial set and starts over. Continuous modes repeat sets indefinitely. Single-shot modes produce one set and then stop until the next write. Power-down stops all conversions, and the next active write waits out a recovery delay. All times are counted in clock cycles, where one microsecond equals `TICKS_PER_US` cycles.

Top module: `avg_conv_seq`

## Requirements
- R1: While reset is held and just after it, the four results read zero, `set_done` is low and no `adc_start` is issued. After reset the block is powered down.
- R2: The mode uses bit 0 to enable the shunt channel, bit 1 to enable the bus channel and bit 2 to select continuous operation. With both channels on, every sample converts shunt (`adc_chan`=0) and then bus (`adc_chan`=1).
- R3: A single-shot mode (bit 2 low, bits 1:0 nonzero) produces exactly one set and then issues no conversion. Writing the same mode again produces another set.
- R4: A disabled channel is never converted. Its two results (shunt and current, or bus and power) keep their previous values when a set completes.
- R5: Each conversion lasts T cycles and consecutive requests inside a set are T+2 cycles apart. T = TICKS_PER_US times 140, 204, 332, 588, 1100, 2116, 4156 or 8244 for time codes 0 to 7. The shunt channel uses its own code and the bus channel uses its own code.
- R6: The current is bits 15:0 of (signed shunt × calibration) arithmetically shifted right by 11. The power is bits 15:0 of (|latest current| × bus) shifted right by 15.
- R7: When the calibration value is zero, the current and power contributions are zero.
- R8: Averaging codes 0 to 7 select 1, 4, 16, 64, 128, 256, 512 or 1024 samples. Each result is the low 16 bits of the lane sum shifted right by log2 of the count. The shift is arithmetic for shunt and current.
- R9: The results change only on the edge that also raises `set_done`, which is high for exactly one cycle.
- R10: Power-down (bits 1:0 zero) issues no conversion and keeps the results. The first request after a write that leaves power-down comes 40×TICKS_PER_US cycles later than it would from an active state. A write during a set discards that set's partial sums.
- R11: `adc_start` is a one-cycle pulse. `adc_done` is accepted only while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode: bit0 shunt, bit1 bus, bit2 continuous |
| cfg_ct_shunt | input | 3 | Shunt conversion-time code |
| cfg_ct_bus | input | 3 | Bus conversion-time code |
| cfg_avg | input | 3 | Averaging code |
| cal | input | CAL_W | Calibration scale factor |
| adc_start | output | 1 | Conversion request pulse |
| adc_chan | output | 1 | Requested channel, 0 shunt, 1 bus |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | DATA_W | Converter result |
| res_shunt | output | DATA_W | Averaged shunt value (signed) |
| res_bus | output | DATA_W | Averaged bus value |
| res_cur | output | DATA_W | Averaged current (signed) |
| res_pwr | output | DATA_W | Averaged power |
| set_done | output | 1 | One-cycle pulse when results load |

## Verification
Some properties hold on every cycle, and the embedded assertions check these. They cover the single-cycle shape of `adc_start` and `set_done`, and the rule that results move only when `set_done` is raised. They also check that nothing is requested while asleep, that the sample index stays within the averaging count and that the pacing counter loads correctly. The arithmetic cannot be checked cycle by cycle, and neither can the channel order, the exact gaps for each time code, the wake delay, single-shot termination or the discard of partial sets. Only the bench's scenarios show these. It mixes random converter data, calibration values and modes with directed extremes, and compares against its own sums.

// File: rtl/avgseq_pkg.sv
// Shared constants, state type and code-decoding functions for the
// averaging conversion sequencer. Assumes 3-bit time and averaging codes.
package avgseq_pkg;

    localparam int MAX_SHIFT  = 10;    // log2 of the largest averaging count
    localparam int CUR_SHIFT  = 11;    // current = shunt*cal >>> CUR_SHIFT
    localparam int PWR_SHIFT  = 15;    // power = |cur|*bus >> PWR_SHIFT
    localparam int CT_US_MAX  = 8244;  // longest conversion time in us
    localparam int WAKE_US    = 40;    // recovery after power-down in us

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_START,
        ST_CONV,
        ST_SAMPLE,
        ST_LOAD
    } seq_state_t;

    // Nominal conversion time in microseconds for a time code.
    function automatic int unsigned ct_us(input logic [2:0] code);
        case (code)
            3'd0:    return 140;
            3'd1:    return 204;
            3'd2:    return 332;
            3'd3:    return 588;
            3'd4:    return 1100;
            3'd5:    return 2116;
            3'd6:    return 4156;
            default: return 8244;
        endcase
    endfunction

    // log2 of the sample count selected by an averaging code.
    function automatic int unsigned avg_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            3'd5:    return 8;
            3'd6:    return 9;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/avgseq_timer.sv
// Loadable down-counter that paces conversions and the wake delay.
// Assumes load has priority over run; zero is high while the count is 0.
module avgseq_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/avgseq_math.sv
// Combinational current and power arithmetic for one sample.
// Assumes shunt and current are two's complement, bus and cal unsigned.
module avgseq_math
    import avgseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 16
) (
    input  logic [DATA_W-1:0] shunt,
    input  logic [DATA_W-1:0] bus,
    input  logic [CAL_W-1:0]  cal,
    input  logic [DATA_W-1:0] cur_in,
    output logic [DATA_W-1:0] cur_out,
    output logic [DATA_W-1:0] pwr_out
);

    localparam int PROD_W = DATA_W + CAL_W + 1;
    localparam int PWR_W  = 2 * DATA_W;

    logic signed [PROD_W-1:0] cur_prod;
    logic signed [PROD_W-1:0] cur_scaled;
    logic        [DATA_W-1:0] cur_mag;
    logic        [PWR_W-1:0]  pwr_prod;
    logic        [PWR_W-1:0]  pwr_scaled;

    // Current: signed shunt times calibration, scaled down.
    always_comb begin
        cur_prod   = $signed({{(CAL_W+1){shunt[DATA_W-1]}}, shunt})
                   * $signed({{(DATA_W+1){1'b0}}, cal});
        cur_scaled = cur_prod >>> CUR_SHIFT;
        cur_out    = cur_scaled[DATA_W-1:0];
    end

    // Power: magnitude of latest current times bus, forced to zero without calibration.
    always_comb begin
        cur_mag    = cur_in[DATA_W-1] ? (~cur_in + 1'b1) : cur_in;
        pwr_prod   = {{DATA_W{1'b0}}, cur_mag} * {{DATA_W{1'b0}}, bus};
        pwr_scaled = pwr_prod >> PWR_SHIFT;
        pwr_out    = (cal == '0) ? '0 : pwr_scaled[DATA_W-1:0];
    end

endmodule

// File: rtl/avgseq_accum.sv
// Bank of signed sum registers, one per result lane, with a shared
// right-shift for averaging. Assumes callers extend each lane value.
module avgseq_accum #(
    parameter int LANES  = 4,
    parameter int LANE_W = 17,
    parameter int ACC_W  = 27,
    parameter int SH_W   = 4,
    parameter int OUT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic [LANES-1:0]             add_en,
    input  logic [LANES-1:0][LANE_W-1:0] add_val,
    input  logic [SH_W-1:0]              shift,
    output logic [LANES-1:0][OUT_W-1:0]  avg
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] scaled;

        // Clear or add one sample into this lane's sum.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                acc_q <= '0;
            else if (add_en[g])
                acc_q <= acc_q + $signed({{(ACC_W-LANE_W){add_val[g][LANE_W-1]}}, add_val[g]});
        end

        assign scaled = acc_q >>> shift;
        assign avg[g] = scaled[OUT_W-1:0];
    end

    // R10
    clear_add_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (add_en == '0));

endmodule

// File: rtl/avg_conv_seq.sv
// Top of the averaging conversion sequencer. Holds configuration, runs the
// shunt/bus conversion order, feeds per-sample arithmetic into the sum bank
// and loads the averaged results at the end of each set. Assumes the
// converter answers each adc_start with one adc_done.
module avg_conv_seq
    import avgseq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CAL_W        = 16,
    parameter int TICKS_PER_US = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode,
    input  logic [2:0]        cfg_ct_shunt,
    input  logic [2:0]        cfg_ct_bus,
    input  logic [2:0]        cfg_avg,
    input  logic [CAL_W-1:0]  cal,
    output logic              adc_start,
    output logic              adc_chan,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic [DATA_W-1:0] res_shunt,
    output logic [DATA_W-1:0] res_bus,
    output logic [DATA_W-1:0] res_cur,
    output logic [DATA_W-1:0] res_pwr,
    output logic              set_done
);

    localparam int LANES     = 4;
    localparam int LANE_W    = DATA_W + 1;
    localparam int ACC_W     = LANE_W + MAX_SHIFT;
    localparam int CNT_W     = $clog2(CT_US_MAX * TICKS_PER_US + 1);
    localparam int SMP_W     = MAX_SHIFT + 1;
    localparam int SH_W      = 4;
    localparam int RECOV_CYC = WAKE_US * TICKS_PER_US;

    seq_state_t        state_q;
    logic [2:0]        mode_q, cts_q, ctb_q, avg_q;
    logic              awake_q, got_q, chan_q, done_q;
    logic [SMP_W-1:0]  samp_q, samp_last;
    logic [DATA_W-1:0] data_q, last_cur_q;
    logic [DATA_W-1:0] cur_w, pwr_w;
    logic [DATA_W-1:0] sh_q, bu_q, cu_q, pw_q;
    logic              tmr_load, tmr_run, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              cfg_active, first_chan, acc_clear;
    logic [LANES-1:0]              add_en;
    logic [LANES-1:0][LANE_W-1:0]  add_val;
    logic [LANES-1:0][DATA_W-1:0]  avg_w;
    logic [SH_W-1:0]               shift_w;

    assign cfg_active = |cfg_mode[1:0];
    assign first_chan = ~mode_q[0];
    assign samp_last  = SMP_W'((32'd1 << avg_shift(avg_q)) - 32'd1);
    assign shift_w    = SH_W'(avg_shift(avg_q));

    // Choose what the shared timer loads: wake delay or conversion time.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(RECOV_CYC - 1);
        if (cfg_we) begin
            tmr_load = cfg_active && !awake_q;
        end else if (state_q == ST_START) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ct_us(chan_q ? ctb_q : cts_q) * 32'(TICKS_PER_US) - 32'd1);
        end
    end
    assign tmr_run = (state_q == ST_WAKE) || (state_q == ST_CONV);

    avgseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .zero(tmr_zero)
    );

    avgseq_math #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_math (
        .shunt(data_q), .bus(data_q), .cal(cal), .cur_in(last_cur_q),
        .cur_out(cur_w), .pwr_out(pwr_w)
    );

    // Route the captured sample into the lanes of its channel.
    always_comb begin
        add_en     = '0;
        if (state_q == ST_SAMPLE && !cfg_we)
            add_en = chan_q ? 4'b1100 : 4'b0011;
        add_val[0] = {data_q[DATA_W-1], data_q};
        add_val[1] = {cur_w[DATA_W-1], cur_w};
        add_val[2] = {1'b0, data_q};
        add_val[3] = {1'b0, pwr_w};
    end
    assign acc_clear = cfg_we || (state_q == ST_LOAD);

    avgseq_accum #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W),
                   .SH_W(SH_W), .OUT_W(DATA_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .add_en(add_en),
        .add_val(add_val), .shift(shift_w), .avg(avg_w)
    );

    // Sequence configuration, conversions, sample steps and result loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= 3'b000;
            cts_q      <= '0;
            ctb_q      <= '0;
            avg_q      <= '0;
            awake_q    <= 1'b0;
            got_q      <= 1'b0;
            chan_q     <= 1'b0;
            samp_q     <= '0;
            data_q     <= '0;
            last_cur_q <= '0;
            sh_q <= '0; bu_q <= '0; cu_q <= '0; pw_q <= '0;
            done_q     <= 1'b0;
        end else if (cfg_we) begin
            mode_q  <= cfg_mode;
            cts_q   <= cfg_ct_shunt;
            ctb_q   <= cfg_ct_bus;
            avg_q   <= cfg_avg;
            chan_q  <= ~cfg_mode[0];
            samp_q  <= '0;
            got_q   <= 1'b0;
            done_q  <= 1'b0;
            if (!cfg_active) begin
                awake_q <= 1'b0;
                state_q <= ST_IDLE;
            end else begin
                state_q <= awake_q ? ST_START : ST_WAKE;
            end
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_WAKE: if (tmr_zero) begin
                    awake_q <= 1'b1;
                    state_q <= ST_START;
                end
                ST_START: begin
                    got_q   <= 1'b0;
                    state_q <= ST_CONV;
                end
                ST_CONV: begin
                    if (adc_done) begin
                        data_q <= adc_data;
                        got_q  <= 1'b1;
                    end
                    if (tmr_zero && (got_q || adc_done))
                        state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (!chan_q)
                        last_cur_q <= cur_w;
                    if (!chan_q && mode_q[1]) begin
                        chan_q  <= 1'b1;
                        state_q <= ST_START;
                    end else if (samp_q == samp_last) begin
                        state_q <= ST_LOAD;
                    end else begin
                        samp_q  <= samp_q + 1'b1;
                        chan_q  <= first_chan;
                        state_q <= ST_START;
                    end
                end
                ST_LOAD: begin
                    if (mode_q[0]) begin
                        sh_q <= avg_w[0];
                        cu_q <= avg_w[1];
                    end
                    if (mode_q[1]) begin
                        bu_q <= avg_w[2];
                        pw_q <= avg_w[3];
                    end
                    done_q  <= 1'b1;
                    samp_q  <= '0;
                    chan_q  <= first_chan;
                    state_q <= mode_q[2] ? ST_START : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign adc_start = (state_q == ST_START);
    assign adc_chan  = chan_q;
    assign res_shunt = sh_q;
    assign res_bus   = bu_q;
    assign res_cur   = cu_q;
    assign res_pwr   = pw_q;
    assign set_done  = done_q;

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> !set_done);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_done |-> ($stable(res_shunt) && $stable(res_bus)
                       && $stable(res_cur) && $stable(res_pwr)));
    // R10
    asleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_q |-> !adc_start);
    // R8
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_q <= samp_last);

endmodule

// File: tb/avg_conv_seq_test.sv
module avg_conv_seq_test;

    localparam int RECOV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = '0, cfg_ct_shunt = '0, cfg_ct_bus = '0, cfg_avg = '0;
    logic [15:0] cal = '0;
    logic        adc_start, adc_chan;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = '0;
    logic [15:0] res_shunt, res_bus, res_cur, res_pwr;
    logic        set_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    avg_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_ct_shunt(cfg_ct_shunt), .cfg_ct_bus(cfg_ct_bus), .cfg_avg(cfg_avg),
        .cal(cal), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_data(adc_data), .res_shunt(res_shunt),
        .res_bus(res_bus), .res_cur(res_cur), .res_pwr(res_pwr),
        .set_done(set_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_cur(input logic [15:0] s, input logic [15:0] c);
        longint p;
        p = longint'($signed(s)) * longint'(c);
        p = p >>> 11;
        return p[15:0];
    endfunction

    function automatic logic [15:0] f_pwr(input logic [15:0] cur, input logic [15:0] b,
                                          input logic [15:0] c);
        longint m;
        if (c == 16'd0) return 16'd0;
        m = longint'($signed(cur));
        if (m < 0) m = -m;
        m = (m * longint'(b)) >>> 15;
        return m[15:0];
    endfunction

    function automatic int f_shift(input logic [2:0] a);
        case (a)
            3'd0: return 0;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 7;  3'd5: return 8;  3'd6: return 9;  default: return 10;
        endcase
    endfunction

    function automatic int f_ct(input logic [2:0] c);
        case (c)
            3'd0: return 140;  3'd1: return 204;  3'd2: return 332;  3'd3: return 588;
            3'd4: return 1100; 3'd5: return 2116; 3'd6: return 4156; default: return 8244;
        endcase
    endfunction

    function automatic logic [15:0] gen_data();
        int r;
        r = $urandom % 8;
        if (r == 0) return 16'h8000;
        if (r == 1) return 16'h7FFF;
        if (r == 2) return 16'hFFFF;
        return 16'($urandom);
    endfunction

    // Reference model state
    longint      acc_s = 0, acc_b = 0, acc_c = 0, acc_p = 0;
    logic [15:0] m_last = '0;
    logic [15:0] exp_s = '0, exp_b = '0, exp_c = '0, exp_p = '0;
    logic [2:0]  m_mode = '0, m_avg = '0;
    bit          pend = 0, pchan = 0, exp_chan = 0, order_bad = 0;
    int          pdelay = 0;
    int          set_count = 0;
    int          start_cnt = 0;

    // Converter model and result checker, acting just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            adc_done = 1'b0;
            if (rst_n) begin
                if (set_done) begin
                    if (m_mode[0]) begin
                        exp_s = 16'(acc_s >>> f_shift(m_avg));
                        exp_c = 16'(acc_c >>> f_shift(m_avg));
                    end
                    if (m_mode[1]) begin
                        exp_b = 16'(acc_b >>> f_shift(m_avg));
                        exp_p = 16'(acc_p >>> f_shift(m_avg));
                    end
                    // R8 averaged shunt, R4 hold when disabled
                    check(res_shunt == exp_s, "R8 shunt average", res_shunt, exp_s);
                    check(res_bus == exp_b, "R8 bus average", res_bus, exp_b);
                    // R6 current and power averages
                    check(res_cur == exp_c, "R6 current average", res_cur, exp_c);
                    check(res_pwr == exp_p, "R6 power average", res_pwr, exp_p);
                    // R2 channel order
                    check(order_bad == 0, "R2 channel order", order_bad, 0);
                    acc_s = 0; acc_b = 0; acc_c = 0; acc_p = 0;
                    set_count++;
                end
                if (cfg_we) begin
                    acc_s = 0; acc_b = 0; acc_c = 0; acc_p = 0;
                    pend = 0;
                    m_mode = cfg_mode;
                    m_avg = cfg_avg;
                    exp_chan = ~cfg_mode[0];
                end
                if (adc_start) begin
                    start_cnt++;
                    if (adc_chan != exp_chan) order_bad = 1;
                    pchan = adc_chan;
                    pend = 1;
                    pdelay = 1 + ($urandom % 8);
                end else if (pend) begin
                    pdelay--;
                    if (pdelay == 0) begin
                        logic [15:0] d, cv;
                        d = gen_data();
                        adc_data = d;
                        adc_done = 1'b1;
                        pend = 0;
                        if (!pchan) begin
                            cv = f_cur(d, cal);
                            acc_s += longint'($signed(d));
                            acc_c += longint'($signed(cv));
                            m_last = cv;
                            exp_chan = m_mode[1] ? 1'b1 : 1'b0;
                        end else begin
                            acc_b += longint'(d);
                            acc_p += longint'(f_pwr(m_last, d, cal));
                            exp_chan = m_mode[0] ? 1'b0 : 1'b1;
                        end
                    end
                end
            end
        end
    end

    task automatic write_cfg(input logic [2:0] m, input logic [2:0] cs,
                             input logic [2:0] cb, input logic [2:0] a);
        @(negedge clk);
        cfg_mode = m; cfg_ct_shunt = cs; cfg_ct_bus = cb; cfg_avg = a;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_sets(input int k);
        int target;
        target = set_count + k;
        while (set_count < target) @(negedge clk);
    endtask

    task automatic gap_to_start(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!adc_start);
    endtask

    task automatic wait_start();
        while (!adc_start) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, s0, c0;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(res_shunt == 0 && res_bus == 0, "R1 reset results", res_shunt, 0);
        check(res_cur == 0 && res_pwr == 0, "R1 reset derived", res_cur, 0);
        check(set_done == 0 && adc_start == 0, "R1 reset strobes", set_done, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check(start_cnt == 0, "R1 powered down after reset", start_cnt, 0);

        // R10 wake delay from power-down, R2 continuous both channels
        cal = 16'd3000;
        write_cfg(3'b111, 3'd0, 3'd0, 3'd1);
        n = 0;
        while (!adc_start) begin @(negedge clk); n++; end
        check(n == RECOV, "R10 wake delay", n, RECOV);
        wait_sets(3);

        // R5 shunt time codes (continuous shunt-only, 4 samples)
        for (int code = 0; code < 8; code++) begin
            write_cfg(3'b101, 3'(code), 3'd0, 3'd1);
            wait_start();
            gap_to_start(n);
            check(n == f_ct(3'(code)) + 2, "R5 shunt conversion gap", n, f_ct(3'(code)) + 2);
        end

        // R5 independent bus time code
        write_cfg(3'b111, 3'd0, 3'd3, 3'd1);
        wait_start();
        gap_to_start(n);
        check(n == f_ct(3'd0) + 2, "R5 shunt-to-bus gap", n, f_ct(3'd0) + 2);
        gap_to_start(n);
        check(n == f_ct(3'd3) + 2, "R5 bus-to-shunt gap", n, f_ct(3'd3) + 2);

        // R3 single shot stops, rewrite restarts
        cal = 16'($urandom);
        write_cfg(3'b011, 3'd0, 3'd1, 3'd0);
        wait_sets(1);
        s0 = start_cnt; c0 = set_count;
        repeat (3000) @(negedge clk);
        check(start_cnt == s0, "R3 no conversion after single shot", start_cnt, s0);
        check(set_count == c0, "R3 no second set", set_count, c0);
        write_cfg(3'b011, 3'd0, 3'd1, 3'd0);
        wait_sets(1);
        check(set_count == c0 + 1, "R3 rewrite gives new set", set_count, c0 + 1);

        // R4 bus only (power from held current), then shunt only
        write_cfg(3'b010, 3'd0, 3'd0, 3'd1);
        wait_sets(1);
        write_cfg(3'b001, 3'd0, 3'd0, 3'd1);
        wait_sets(1);

        // R7 calibration zero
        cal = 16'd0;
        write_cfg(3'b011, 3'd0, 3'd0, 3'd1);
        wait_sets(1);
        check(res_cur == 0, "R7 current with zero cal", res_cur, 0);
        check(res_pwr == 0, "R7 power with zero cal", res_pwr, 0);

        // R8 sixteen-sample average
        cal = 16'd4096;
        write_cfg(3'b111, 3'd0, 3'd0, 3'd2);
        wait_sets(2);

        // Random modes and calibration values
        for (int i = 0; i < 8; i++) begin
            logic [2:0] m;
            case ($urandom % 6)
                0: m = 3'b001; 1: m = 3'b010; 2: m = 3'b011;
                3: m = 3'b101; 4: m = 3'b110; default: m = 3'b111;
            endcase
            cal = (($urandom % 5) == 0) ? 16'd0 : 16'($urandom);
            write_cfg(m, 3'($urandom % 2), 3'($urandom % 2), 3'($urandom % 2));
            wait_sets(1);
        end

        // R10 write mid-set discards, power-down holds results
        cal = 16'd777;
        write_cfg(3'b111, 3'd0, 3'd0, 3'd1);
        repeat (3) begin wait_start(); @(negedge clk); end
        write_cfg(3'b000, 3'd0, 3'd0, 3'd0);
        s0 = start_cnt; c0 = set_count;
        repeat (1000) @(negedge clk);
        check(start_cnt == s0, "R10 no conversion in power-down", start_cnt, s0);
        check(set_count == c0, "R10 no set in power-down", set_count, c0);
        check(res_shunt == exp_s && res_pwr == exp_p, "R10 results held", res_shunt, exp_s);
        write_cfg(3'b011, 3'd0, 3'd0, 3'd0);
        n = 0;
        while (!adc_start) begin @(negedge clk); n++; end
        check(n == RECOV, "R10 second wake delay", n, RECOV);
        wait_sets(1);
        // R11 one conversion outstanding per request
        check(order_bad == 0, "R11 request sequence", order_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule